// File: doc/BRIEF.md
# Folded Symmetric FIR Filter (17 taps)

This block is a linear-phase finite impulse response filter of odd length, 17 taps by default. It accepts one signed sample each time its sample strobe is raised. A typical source is a converter that is restarted at a fixed, slow period. For each accepted sample it produces one filtered result and marks that result with a single-cycle valid pulse.

The impulse response is mirror-symmetric, so only the nine distinct coefficients are stored, as a packed parameter. Before each multiply, the two samples that share a coefficient are summed, so a result takes nine products instead of seventeen. The sample period is far longer than the clock period, so a single multiply-accumulate unit is reused for all nine products, one per clock. The result is the accumulator shifted arithmetically right by the number of coefficient fraction bits, with plain truncation.

A strobe that arrives while a computation is in progress is dropped, and this sets a sticky overrun indication. The reset is asynchronous and active-low, and it is released synchronously inside the block.

Top module: `fold_fir_core`

## Requirements
- R1: While reset is asserted and after it is released, `res_vld` is 0, `overrun` is 0 and `res_out` is 0. All stored samples are zero, so the first result after reset depends only on samples accepted after reset.
- R2: Each result equals floor(sum over k=0..16 of h(k)·x(n-k) / 2^FRAC_W). Here x(n) is the newest accepted sample, and older samples are numbered in order of acceptance.
- R3: Coefficient entry k (bits [k·COEF_W +: COEF_W] of `COEFS`, for k=0..8) weights both x(n-k) and x(n-16+k). A unit impulse therefore gives a response sequence that reads the same forwards and backwards.
- R4: `res_vld` rises exactly nine clock cycles after the rising edge that accepted the strobe. That edge is followed by one multiply-accumulate step per unique coefficient.
- R5: `res_vld` is high for exactly one cycle per accepted sample.
- R6: A strobe sampled on any of the nine cycles of a computation is ignored. It does not shift the sample history and does not change the result being computed.
- R7: An ignored strobe sets `overrun`. The flag then stays at 1 until reset.
- R8: Full-scale inputs of either sign over the whole history give the exact result, with no wrap-around. The accumulator is DATA_W+COEF_W+5 bits wide.
- R9: `res_out` holds its value from the valid pulse until the clock edge that accepts the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, sampled on the rising edge |
| smp_in | input | DATA_W | Signed two's-complement input sample |
| res_out | output | DATA_W+COEF_W+5-FRAC_W | Signed filtered result |
| res_vld | output | 1 | One-cycle pulse marking a new result |
| overrun | output | 1 | Sticky flag: a strobe was dropped |

## Verification
Embedded properties check on every cycle that the valid pulse lasts a single cycle and follows the last multiply step. They also check that a strobe during a computation sets the sticky flag and leaves the history frozen, that the accumulator never leaves its range, and that the output stays still while idle. Arithmetic correctness can only be shown by the bench scenarios. These cover the symmetric impulse response, mixed-sign sample streams, full-scale histories of both signs, exact latency, and a result computed while strobes were being dropped that still matches the model built only from accepted samples.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fir_state_e;

  localparam int GUARD_BITS = 5;

endpackage

// File: rtl/fold_fir_ctrl.sv
module fold_fir_ctrl
  import fold_fir_pkg::*;
#(
  parameter int NUNIQ = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  output logic             start,
  output logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             res_vld,
  output logic             overrun
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUNIQ - 1);

  fir_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    vld_d   = 1'b0;
    ovr_d   = ovr_q;
    start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (smp_stb) begin
          start   = 1'b1;
          state_d = ST_RUN;
          idx_d   = '0;
        end
      end
      ST_RUN: begin
        if (smp_stb) begin
          ovr_d = 1'b1;
        end
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          vld_d   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vld_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      vld_q   <= vld_d;
      ovr_q   <= ovr_d;
    end
  end

  assign step    = (state_q == ST_RUN);
  assign busy    = step;
  assign idx     = idx_q;
  assign res_vld = vld_q;
  assign overrun = ovr_q;

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld); // R5
  AST_VLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx == LAST_IDX) |=> res_vld); // R4
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && smp_stb) |=> overrun); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7

endmodule

// File: rtl/fold_fir_taps.sv
module fold_fir_taps #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 17,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  input  logic        [IDX_W-1:0]  sel,
  output logic signed [DATA_W:0]   pre_out
);

  localparam int HALF  = (TAPS - 1) / 2;
  localparam int NUNIQ = HALF + 1;

  logic signed [DATA_W-1:0] tap_q [TAPS];
  logic signed [DATA_W:0]   pair_sum [NUNIQ];

  for (genvar i = 0; i < TAPS; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_q[i] <= '0;
      end else if (shift_en) begin
        if (i == 0) begin
          tap_q[i] <= din;
        end else begin
          tap_q[i] <= tap_q[(i == 0) ? 0 : i - 1];
        end
      end
    end
  end

  for (genvar k = 0; k < NUNIQ; k++) begin : g_fold
    if (k < HALF) begin : g_pair
      assign pair_sum[k] = {tap_q[k][DATA_W-1], tap_q[k]}
                         + {tap_q[TAPS-1-k][DATA_W-1], tap_q[TAPS-1-k]};
    end else begin : g_centre
      assign pair_sum[k] = {tap_q[k][DATA_W-1], tap_q[k]};
    end
  end

  always_comb begin
    pre_out = '0;
    for (int k = 0; k < NUNIQ; k++) begin
      if (sel == IDX_W'(k)) begin
        pre_out = pair_sum[k];
      end
    end
  end

  AST_TAPS_FROZEN_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(tap_q[0])); // R6
  AST_TAPS_FROZEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(tap_q[TAPS-1])); // R6

endmodule

// File: rtl/fold_fir_mac.sv
module fold_fir_mac #(
  parameter int PRE_W  = 17,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 37,
  parameter int NUNIQ  = 9,
  parameter int IDX_W  = 4,
  parameter logic [NUNIQ*COEF_W-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step,
  input  logic [IDX_W-1:0]        idx,
  input  logic signed [PRE_W-1:0] pre_in,
  output logic signed [ACC_W-1:0] acc_out
);

  localparam int PROD_W = PRE_W + COEF_W;

  logic signed [COEF_W-1:0] coef_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [ACC_W:0]    wide_sum;

  always_comb begin
    coef_sel = '0;
    for (int k = 0; k < NUNIQ; k++) begin
      if (idx == IDX_W'(k)) begin
        coef_sel = COEFS[k*COEF_W +: COEF_W];
      end
    end
  end

  assign prod     = pre_in * coef_sel;
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign wide_sum = {acc_q[ACC_W-1], acc_q} + {prod_ext[ACC_W-1], prod_ext};

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (step) begin
      acc_d = acc_q + prod_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr || step) begin
      acc_q <= acc_d;
    end
  end

  assign acc_out = acc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1])); // R8

endmodule

// File: rtl/fold_fir_core.sv
module fold_fir_core
  import fold_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter int TAPS   = 17,
  parameter logic [((TAPS+1)/2)*COEF_W-1:0] COEFS = {
    16'd2400, 16'd2250, 16'd1900, 16'd1350, 16'd750,
    16'd300,  16'd0,    16'hFF97, 16'hFFC4 },
  localparam int ACC_W = DATA_W + COEF_W + GUARD_BITS,
  localparam int OUT_W = ACC_W - FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic signed [DATA_W-1:0] smp_in,
  output logic signed [OUT_W-1:0] res_out,
  output logic                    res_vld,
  output logic                    overrun
);

  localparam int NUNIQ = (TAPS + 1) / 2;
  localparam int IDX_W = (NUNIQ > 1) ? $clog2(NUNIQ) : 1;
  localparam int PRE_W = DATA_W + 1;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic                     start, step, busy;
  logic [IDX_W-1:0]         idx;
  logic signed [PRE_W-1:0]  pre_sum;
  logic signed [ACC_W-1:0]  acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  fold_fir_ctrl #(.NUNIQ(NUNIQ), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .smp_stb(smp_stb),
    .start(start), .step(step), .idx(idx), .busy(busy),
    .res_vld(res_vld), .overrun(overrun)
  );

  fold_fir_taps #(.DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W)) taps_i (
    .clk(clk), .rst_n(rst_int_n), .shift_en(start),
    .din(smp_in), .sel(idx), .pre_out(pre_sum)
  );

  fold_fir_mac #(
    .PRE_W(PRE_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .NUNIQ(NUNIQ), .IDX_W(IDX_W), .COEFS(COEFS)
  ) mac_i (
    .clk(clk), .rst_n(rst_int_n), .clr(start), .step(step),
    .idx(idx), .pre_in(pre_sum), .acc_out(acc)
  );

  assign res_out = OUT_W'(acc >>> FRAC_W);

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !start) |=> $stable(res_out)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!res_vld && !overrun)); // R1

endmodule

// File: tb/fold_fir_core_tb.sv
module fold_fir_core_tb_top;

  localparam int DATA_W = 16;
  localparam int FRAC_W = 14;
  localparam int OUT_W  = 16 + 16 + 5 - FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [DATA_W-1:0] smp_in = '0;
  logic signed [OUT_W-1:0]  res_out;
  logic res_vld, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint hist [17];
  int hb [9] = '{-60, -105, 0, 300, 750, 1350, 1900, 2250, 2400};

  localparam int NVEC = 24;
  localparam logic signed [15:0] VEC [NVEC] = '{
    16'sd16384, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd1000, -16'sd2000, 16'sd3, -16'sd7, 16'sd12345,
    -16'sd30000, 16'sd777 };

  always #4 clk = ~clk;

  fold_fir_core dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .res_out(res_out), .res_vld(res_vld), .overrun(overrun)
  );

  function automatic int coef_at(int k);
    return (k <= 8) ? hb[k] : hb[16-k];
  endfunction

  function automatic longint model_out();
    longint s = 0;
    for (int k = 0; k < 17; k++) s += longint'(coef_at(k)) * hist[k];
    return s >>> FRAC_W;
  endfunction

  task automatic model_push(longint v);
    for (int k = 16; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
  endtask

  task automatic model_clear();
    for (int k = 0; k < 17; k++) hist[k] = 0;
  endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  // Feed one sample; extra_stb holds the strobe high through the run (dropped).
  task automatic feed(logic signed [15:0] s, bit extra_stb, string req);
    int cnt = 0;
    longint exp;
    @(negedge clk);
    smp_stb = 1'b1;
    smp_in  = s;
    @(negedge clk);
    if (extra_stb) begin
      smp_in = ~s;
    end else begin
      smp_stb = 1'b0;
    end
    model_push(longint'(s));
    while (!res_vld && cnt < 50) begin
      @(negedge clk);
      cnt++;
      if (cnt == 9) smp_stb = 1'b0;
    end
    smp_stb = 1'b0;
    exp = model_out();
    check(longint'(res_out) == exp, req, longint'(res_out), exp);
    check(cnt == 9, "R4 latency", cnt, 9);
    @(negedge clk);
    check(res_vld == 1'b0, "R5 single pulse", res_vld, 0);
  endtask

  initial begin
    longint held;
    model_clear();
    // R1: state during and after reset
    repeat (2) @(negedge clk);
    check(res_vld == 0 && overrun == 0, "R1 vld/ovr in reset", {res_vld, overrun}, 0);
    do_reset();
    check(res_out == 0, "R1 res_out after reset", longint'(res_out), 0);
    check(res_vld == 0 && overrun == 0, "R1 vld/ovr after reset", {res_vld, overrun}, 0);

    // R2/R3: table walk, impulse first gives the symmetric response
    for (int i = 0; i < NVEC; i++) begin
      feed(VEC[i], 1'b0, (i < 17) ? "R3 impulse response" : "R2 mixed stream");
    end
    check(overrun == 0, "R7 no overrun yet", overrun, 0);

    // R9: output held while idle
    held = longint'(res_out);
    repeat (20) @(negedge clk);
    check(longint'(res_out) == held, "R9 hold", longint'(res_out), held);

    // R8: full-scale positive then negative histories
    for (int i = 0; i < 17; i++) feed(16'sd32767, 1'b0, "R8 full positive");
    for (int i = 0; i < 17; i++) feed(-16'sd32768, 1'b0, "R8 full negative");

    // R6/R7: strobes during every busy cycle are dropped
    feed(16'sd5000, 1'b1, "R6 dropped strobes");
    check(overrun == 1, "R7 overrun set", overrun, 1);
    feed(-16'sd1234, 1'b0, "R6 history unaffected");
    repeat (5) @(negedge clk);
    check(overrun == 1, "R7 overrun sticky", overrun, 1);

    // R1: reset mid-run clears flag and history
    @(negedge clk);
    smp_stb = 1'b1;
    smp_in = 16'sd9999;
    @(negedge clk);
    smp_stb = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    check(overrun == 0 && res_vld == 0, "R1 reset mid-run", {overrun, res_vld}, 0);
    feed(16'sd16384, 1'b0, "R1 history cleared");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule